// File: doc/BRIEF.md
# Amplitude-Timed Oscillator Gating Controller

This block saves power in a crystal oscillator by switching its sustaining amplifier on and off. The oscillator output itself clocks the block. Two comparator bits report whether the oscillation amplitude lies above a low threshold and above a high threshold.

After a start request, the block measures two intervals. The first is how many oscillator cycles the amplitude needs to climb from the low threshold to the high one while the amplifier is on. The second is how many cycles it needs to fall back through the band between the thresholds while the amplifier is off. Both counts are held in registers, and the measurement logic then stays idle. From then on, the block generates a duty clock. The clock is high for the growth count and low for the decay count, so its period is the sum of the two. The amplifier is on only while the duty clock is high. With a 32.768 kHz oscillator, the duty clock lands roughly in the 2 to 50 Hz range. A mode input chooses between duty cycling and keeping the amplifier on all the time.

Top module: `osc_gate_ctrl`

## Requirements
- R1: While reset is held and right after it, amp_en is 1, duty_clk is 0, meas_done is 0, and both stored counts are 0.
- R2: Before start and during growth measurement, amp_en is 1. After start, the block waits for thr_lo to be sampled high. The stored growth count is then the number of later rising edges that sample thr_hi low, up to the edge that samples thr_hi high.
- R3: The edge that samples thr_hi high during growth begins decay measurement, and amp_en is 0 from that edge on. The decay count is the number of edges that sample thr_hi low and thr_lo high. Edges that still sample thr_hi high are not counted.
- R4: The edge that samples thr_lo low during decay stores the decay count and sets meas_done. meas_done then stays 1 until reset.
- R5: When meas_done is 1 and run_en is 1, duty_clk starts high on the cycle meas_done rises. It stays high for the growth count in cycles, then low for the decay count in cycles, and repeats. duty_clk is 0 whenever meas_done is 0.
- R6: While meas_done and run_en are both 1, amp_en equals duty_clk.
- R7: When run_en is 0 after measurement, amp_en is 1 and duty_clk is 0. When run_en is raised again, the loop restarts in its high phase.
- R8: A stored count of 0 acts as a one-cycle phase.
- R9: The measurement counter saturates at 2^CNT_W-1 instead of wrapping.
- R10: start is ignored except in the idle state. After measurement, a start pulse leaves both counts and meas_done unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator output used as clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the measurement sequence (idle only) |
| run_en | input | 1 | 1: duty cycle after measurement; 0: amplifier always on |
| thr_lo | input | 1 | Amplitude above low threshold |
| thr_hi | input | 1 | Amplitude above high threshold |
| amp_en | output | 1 | Amplifier enable |
| duty_clk | output | 1 | Gating clock |
| grow_cnt | output | CNT_W | Stored growth interval |
| decay_cnt | output | CNT_W | Stored decay interval |
| meas_done | output | 1 | Both intervals stored |

## Verification
Every stored count and meas_done changes on the same rising edge that samples the comparator ending its interval. duty_clk and amp_en are decoded from registers, and they also follow the run_en level with no clock delay. The bench changes inputs a quarter period after each rising edge and compares all outputs with its model at the falling edge. The directed checks are placed the stated number of edges after each comparator change, so a result one cycle early or late is reported.

// File: rtl/osc_gate_pkg.sv
package osc_gate_pkg;
    typedef enum logic [2:0] {
        MS_IDLE,
        MS_WAIT_LO,
        MS_GROW,
        MS_DECAY,
        MS_DONE
    } meas_st_e;
endpackage

// File: rtl/osc_gate_meas.sv
module osc_gate_meas
    import osc_gate_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             thr_lo,
    input  logic             thr_hi,
    output logic             amp_req,
    output logic [CNT_W-1:0] grow_cnt,
    output logic [CNT_W-1:0] decay_cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        meas_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] grow;
        logic [CNT_W-1:0] decay;
    } meas_t;

    meas_t m_d, m_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    always_comb begin
        m_d = m_q;
        case (m_q.st)
            MS_IDLE: begin
                if (start) begin
                    m_d.st  = MS_WAIT_LO;
                    m_d.cnt = '0;
                end
            end
            MS_WAIT_LO: begin
                if (thr_lo) begin
                    m_d.st  = MS_GROW;
                    m_d.cnt = '0;
                end
            end
            MS_GROW: begin
                if (thr_hi) begin
                    m_d.grow = m_q.cnt;
                    m_d.cnt  = '0;
                    m_d.st   = MS_DECAY;
                end else begin
                    m_d.cnt = sat_inc(m_q.cnt);
                end
            end
            MS_DECAY: begin
                if (!thr_lo) begin
                    m_d.decay = m_q.cnt;
                    m_d.st    = MS_DONE;
                end else if (!thr_hi) begin
                    m_d.cnt = sat_inc(m_q.cnt);
                end
            end
            MS_DONE: ;
            default: m_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{st: MS_IDLE, cnt: '0, grow: '0, decay: '0};
        end else begin
            m_q <= m_d;
        end
    end

    assign amp_req   = (m_q.st != MS_DECAY);
    assign done      = (m_q.st == MS_DONE);
    assign grow_cnt  = m_q.grow;
    assign decay_cnt = m_q.decay;
endmodule

// File: rtl/osc_gate_loop.sv
module osc_gate_loop #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             duty_clk
);
    typedef struct packed {
        logic             hi;
        logic [CNT_W-1:0] cnt;
    } loop_t;

    loop_t l_d, l_q;
    logic [CNT_W-1:0] lim_raw;
    logic [CNT_W-1:0] lim_eff;

    always_comb begin
        l_d     = l_q;
        lim_raw = l_q.hi ? hi_len : lo_len;
        lim_eff = (lim_raw == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : lim_raw;
        if (!enable) begin
            l_d.hi  = 1'b1;
            l_d.cnt = '0;
        end else if (l_q.cnt == lim_eff - 1'b1) begin
            l_d.hi  = ~l_q.hi;
            l_d.cnt = '0;
        end else begin
            l_d.cnt = l_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '{hi: 1'b1, cnt: '0};
        end else begin
            l_q <= l_d;
        end
    end

    assign duty_clk = enable & l_q.hi;
endmodule

// File: rtl/osc_gate_ctrl.sv
module osc_gate_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run_en,
    input  logic             thr_lo,
    input  logic             thr_hi,
    output logic             amp_en,
    output logic             duty_clk,
    output logic [CNT_W-1:0] grow_cnt,
    output logic [CNT_W-1:0] decay_cnt,
    output logic             meas_done
);
    logic amp_req;
    logic loop_en;

    osc_gate_meas #(.CNT_W(CNT_W)) u_meas (
        .clk       (osc_clk),
        .rst_n     (rst_n),
        .start     (start),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .amp_req   (amp_req),
        .grow_cnt  (grow_cnt),
        .decay_cnt (decay_cnt),
        .done      (meas_done)
    );

    assign loop_en = meas_done & run_en;

    osc_gate_loop #(.CNT_W(CNT_W)) u_loop (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .enable   (loop_en),
        .hi_len   (grow_cnt),
        .lo_len   (decay_cnt),
        .duty_clk (duty_clk)
    );

    assign amp_en = meas_done ? (run_en ? duty_clk : 1'b1) : amp_req;
endmodule

// File: rtl/osc_gate_chk.sv
module osc_gate_chk #(
    parameter int CNT_W = 16
) (
    input logic             osc_clk,
    input logic             rst_n,
    input logic             start,
    input logic             run_en,
    input logic             amp_en,
    input logic             duty_clk,
    input logic [CNT_W-1:0] grow_cnt,
    input logic [CNT_W-1:0] decay_cnt,
    input logic             meas_done
);
    AST_AMP_TRACKS_DUTY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (meas_done && run_en) |-> (amp_en == duty_clk)); // R6

    AST_NO_DUTY_EARLY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !meas_done |-> !duty_clk); // R5

    AST_DONE_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_n)
        meas_done |=> meas_done); // R4

    AST_COUNTS_HELD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        meas_done |=> ($stable(grow_cnt) && $stable(decay_cnt))); // R10

    AST_AMP_ON_WHEN_PARKED: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (meas_done && !run_en) |-> (amp_en && !duty_clk)); // R7
endmodule

bind osc_gate_ctrl osc_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .start     (start),
    .run_en    (run_en),
    .amp_en    (amp_en),
    .duty_clk  (duty_clk),
    .grow_cnt  (grow_cnt),
    .decay_cnt (decay_cnt),
    .meas_done (meas_done)
);

// File: tb/osc_gate_ctrl_test.sv
module osc_gate_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int CMAX       = 65535;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, run_en = 1'b0;
    logic thr_lo = 1'b0, thr_hi = 1'b0;
    logic amp_en, duty_clk, meas_done;
    logic [W-1:0] grow_cnt, decay_cnt;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    // model: 0 idle, 1 wait low, 2 growth, 3 decay, 4 done
    int m_st = 0, m_cnt = 0, m_g = 0, m_d = 0, m_lc = 0;
    bit m_hi = 1'b1;

    osc_gate_ctrl #(.CNT_W(W)) uut (
        .osc_clk(clk), .rst_n(rst_n), .start(start), .run_en(run_en),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .amp_en(amp_en), .duty_clk(duty_clk),
        .grow_cnt(grow_cnt), .decay_cnt(decay_cnt), .meas_done(meas_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat1(input int v);
        return (v < CMAX) ? v + 1 : CMAX;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_g = 0; m_d = 0; m_lc = 0; m_hi = 1'b1;
        end else begin
            if (!(m_st == 4 && run_en)) begin
                m_hi = 1'b1; m_lc = 0;
            end else begin
                int lim;
                lim = m_hi ? m_g : m_d;
                if (lim == 0) lim = 1;
                if (m_lc + 1 >= lim) begin m_hi = !m_hi; m_lc = 0; end
                else m_lc = m_lc + 1;
            end
            case (m_st)
                0: if (start) begin m_st = 1; m_cnt = 0; end
                1: if (thr_lo) begin m_st = 2; m_cnt = 0; end
                2: if (thr_hi) begin m_g = m_cnt; m_cnt = 0; m_st = 3; end
                   else m_cnt = sat1(m_cnt);
                3: if (!thr_lo) begin m_d = m_cnt; m_st = 4; end
                   else if (!thr_hi) m_cnt = sat1(m_cnt);
                default: ;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_done, e_duty, e_amp;
            e_done = (m_st == 4);
            e_duty = e_done && run_en && m_hi;
            e_amp  = e_done ? (run_en ? m_hi : 1'b1) : (m_st != 3);
            chk("R4 meas_done", int'(meas_done), int'(e_done));
            chk("R5 duty_clk", int'(duty_clk), int'(e_duty));
            chk(m_st == 3 ? "R3 amp_en" : "R6 amp_en", int'(amp_en), int'(e_amp));
            chk("R2 grow_cnt", int'(grow_cnt), m_g);
            chk("R3 decay_cnt", int'(decay_cnt), m_d);
        end
    end

    task automatic tick;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; start = 1'b0; thr_lo = 1'b0; thr_hi = 1'b0;
        repeat (2) tick;
        rst_n = 1'b1;
    endtask

    task automatic pulse_start;
        start = 1'b1; tick; start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        run_en = 1'b1;
        do_reset;
        // R1 reset state
        chk("R1 amp_en", int'(amp_en), 1);
        chk("R1 duty_clk", int'(duty_clk), 0);
        chk("R1 meas_done", int'(meas_done), 0);
        chk("R1 grow_cnt", int'(grow_cnt), 0);
        chk("R1 decay_cnt", int'(decay_cnt), 0);

        // scenario A: growth 6, decay 9
        repeat (3) tick;
        pulse_start;
        repeat (4) tick;                       // waiting for low threshold
        chk("R2 amp_en while waiting", int'(amp_en), 1);
        thr_lo = 1'b1; tick;
        repeat (6) tick;
        chk("R2 amp_en during growth", int'(amp_en), 1);
        thr_hi = 1'b1; tick;
        chk("R3 amp_en off in decay", int'(amp_en), 0);
        repeat (2) tick;                       // still above high: not counted
        thr_hi = 1'b0;
        repeat (9) tick;
        chk("R4 done not early", int'(meas_done), 0);
        thr_lo = 1'b0; tick;
        chk("R4 meas_done", int'(meas_done), 1);
        chk("R2 grow_cnt", int'(grow_cnt), 6);
        chk("R3 decay_cnt", int'(decay_cnt), 9);
        chk("R5 first high", int'(duty_clk), 1);
        repeat (5) tick;
        chk("R5 end of high phase", int'(duty_clk), 1);
        tick;
        chk("R5 low phase", int'(duty_clk), 0);
        chk("R6 amp off in low phase", int'(amp_en), 0);
        repeat (8) tick;
        chk("R5 end of low phase", int'(duty_clk), 0);
        tick;
        chk("R5 high again", int'(duty_clk), 1);
        chk("R6 amp on in high phase", int'(amp_en), 1);
        repeat (7) tick;
        pulse_start;
        chk("R10 grow kept", int'(grow_cnt), 6);
        chk("R10 decay kept", int'(decay_cnt), 9);
        chk("R10 done kept", int'(meas_done), 1);
        run_en = 1'b0; #1;
        chk("R7 amp forced on", int'(amp_en), 1);
        chk("R7 duty off", int'(duty_clk), 0);
        repeat (3) tick;
        chk("R7 amp stays on", int'(amp_en), 1);
        run_en = 1'b1; #1;
        chk("R7 restart high", int'(duty_clk), 1);
        repeat (20) tick;

        // scenario B: both counts zero
        do_reset;
        pulse_start;
        thr_lo = 1'b1; thr_hi = 1'b1; tick;
        tick;
        thr_lo = 1'b0; thr_hi = 1'b0; tick;
        chk("R8 grow zero", int'(grow_cnt), 0);
        chk("R8 decay zero", int'(decay_cnt), 0);
        chk("R8 high one cycle", int'(duty_clk), 1);
        tick;
        chk("R8 low one cycle", int'(duty_clk), 0);
        tick;
        chk("R8 high again", int'(duty_clk), 1);
        repeat (6) tick;

        // scenario C: saturation of the growth count
        run_en = 1'b0;
        do_reset;
        pulse_start;
        thr_lo = 1'b1; tick;
        repeat (70000) tick;
        thr_hi = 1'b1; tick;
        thr_hi = 1'b0;
        repeat (3) tick;
        thr_lo = 1'b0; tick;
        chk("R9 grow saturated", int'(grow_cnt), CMAX);
        chk("R9 decay after saturation", int'(decay_cnt), 3);
        chk("R7 amp on, run off", int'(amp_en), 1);
        repeat (4) tick;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule